// File: doc/BRIEF.md
# Selectable Deadtime Gate Generator

This block drives the two switches of a half bridge from one PWM input. It produces a high-side enable that follows the PWM level and a low-side enable that is its complement. At every PWM transition it first turns off the output that is on. Only after a non-overlap interval does it turn on the other one. The interval is the same for rising and falling PWM edges, so the duty-cycle distortion it adds is symmetric.

The interval is one of four presets, chosen by a 2-bit mode code. The code replaces an analog level decoder, and a higher code gives a shorter interval. The presets are given in picoseconds and turned into clock-cycle counts from a clock-period parameter. A shutdown input from the protection logic forces both enables low at once, without waiting for a clock edge. After shutdown is released, the block waits a full interval before it turns anything on. The mode code is read only when a PWM transition is accepted, so changing it in the middle of a cycle never shortens an interval that has already started.

Top module: `gate_deadtime_gen`

## Requirements
- R1: Once the interval has elapsed, `hi_en` equals the level of `pwm_in` and `lo_en` is its inverse, and they stay so while the PWM level holds.
- R2: `dt_mode` selects the interval length N. With the default 1000 ps period, code 2'b11 gives 15 cycles, 2'b10 gives 25, 2'b01 gives 35 and 2'b00 gives 45.
- R3: A PWM change is first seen at rising edge k. Both enables are low after edge k, and the newly selected output rises at edge k+N. This holds in the same way for rising and falling PWM edges.
- R4: `hi_en` and `lo_en` are never high at the same time, including when the mode code changes in the middle of a cycle.
- R5: The mode code is sampled only at the edge that accepts a PWM change. A later change of `dt_mode` does not alter the interval already in progress, and it applies from the next PWM change onward.
- R6: While `shutdown` is high, both enables are low within the same cycle, combinationally. PWM activity during shutdown produces no output pulse.
- R7: Let r be the first rising edge that samples `shutdown` low. The output selected by the PWM level rises at edge r+N-1, so both enables stay low for N cycles after release.
- R8: A PWM level that reverts before its interval has elapsed cancels the pending turn-on. A new full interval of N cycles then starts for the reverted level, and the cancelled side never rises.
- R9: While `rst_n` is low, both enables are low. After release, the first turn-on uses the longest preset, at edge r+44 for the default settings, where r is the first edge with `rst_n` high.
- R10: Each preset count is the preset time divided by `CLK_PERIOD_PS`, rounded up, with a minimum of 1. With a 4000 ps period this gives 4, 7, 9 and 12 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock whose period is `CLK_PERIOD_PS` |
| rst_n | input | 1 | Synchronous active-low reset |
| pwm_in | input | 1 | PWM command, synchronous to `clk` |
| dt_mode | input | 2 | Interval select; a higher code gives a shorter interval |
| shutdown | input | 1 | Forced-off request from the protection logic; gates the outputs combinationally |
| hi_en | output | 1 | High-side enable, in phase with `pwm_in` |
| lo_en | output | 1 | Low-side enable, complement of `pwm_in` |

## Verification
A wrong count or a lost target level shows up at the ports on the next PWM transition. The first output edge after the transition arrives one or more cycles off the expected N, or the wrong side turns on, so the bench measures the exact cycle of every turn-on rather than only the steady levels. A target register that fails to reload on a reverted PWM level, or a mode value that is read continuously instead of latched, shows within one interval as a premature turn-on. Broken gating of the shutdown input shows in the same cycle that `shutdown` rises, as an enable that is still high.

// File: rtl/dt_gate_pkg.sv
`timescale 1ns/1ps
// Package: shared helpers for the deadtime gate generator.
// Assumes preset times and the clock period are positive integers in picoseconds.
package dt_gate_pkg;

    localparam int unsigned DT_PRESETS = 4;

    // Interval codes as driven on the mode input (higher code = shorter interval).
    typedef enum logic [1:0] {
        DT_LONGEST  = 2'b00,
        DT_LONG     = 2'b01,
        DT_SHORT    = 2'b10,
        DT_SHORTEST = 2'b11
    } dt_mode_e;

    // Convert a time in ps into a clock-cycle count, rounded up, at least 1.
    function automatic int unsigned dt_cycles(input int unsigned dt_ps,
                                              input int unsigned period_ps);
        int unsigned c;
        c = (dt_ps + period_ps - 1) / period_ps;
        return (c == 0) ? 1 : c;
    endfunction

    // Largest of four values; used to size the interval counter.
    function automatic int unsigned dt_max4(input int unsigned a, input int unsigned b,
                                            input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/dt_preset_table.sv
`timescale 1ns/1ps
// Module: dt_preset_table
// Maps the 2-bit interval code onto a cycle count and also supplies the
// longest count, which is used after reset.
// Assumes presets are given shortest first (index 0) and longest last.
module dt_preset_table
    import dt_gate_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_PS = 1000,
    parameter int unsigned DT_PS_0       = 15000,
    parameter int unsigned DT_PS_1       = 25000,
    parameter int unsigned DT_PS_2       = 35000,
    parameter int unsigned DT_PS_3       = 45000,
    parameter int unsigned CNT_W         = 6
) (
    input  logic [1:0]       mode_code,
    output logic [CNT_W-1:0] load_cnt,
    output logic [CNT_W-1:0] max_cnt
);

    localparam int unsigned MAX_CYC = dt_max4(dt_cycles(DT_PS_0, CLK_PERIOD_PS),
                                              dt_cycles(DT_PS_1, CLK_PERIOD_PS),
                                              dt_cycles(DT_PS_2, CLK_PERIOD_PS),
                                              dt_cycles(DT_PS_3, CLK_PERIOD_PS));

    logic [CNT_W-1:0] cnt_lut [DT_PRESETS];
    logic [1:0]       lut_idx;

    // One table entry per preset, converted to cycles at elaboration.
    for (genvar g = 0; g < DT_PRESETS; g++) begin : g_preset
        localparam int unsigned PS = (g == 0) ? DT_PS_0 :
                                     (g == 1) ? DT_PS_1 :
                                     (g == 2) ? DT_PS_2 : DT_PS_3;
        assign cnt_lut[g] = CNT_W'(dt_cycles(PS, CLK_PERIOD_PS));
    end

    // Highest code selects index 0 (shortest), lowest code the longest.
    always_comb begin
        lut_idx  = ~mode_code;
        load_cnt = cnt_lut[lut_idx];
        max_cnt  = CNT_W'(MAX_CYC);
    end

endmodule

// File: rtl/dt_interval_timer.sv
`timescale 1ns/1ps
// Module: dt_interval_timer
// Tracks the PWM level being served and counts the non-overlap interval.
// A new PWM level, shutdown or reset reloads the counter. The fire strobe
// marks the cycle in which the interval ends with the level still stable.
// Assumes pwm_in is synchronous to clk and every count is at least 1.
module dt_interval_timer #(
    parameter int unsigned CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shutdown,
    input  logic             pwm_in,
    input  logic [CNT_W-1:0] load_cnt,
    input  logic [CNT_W-1:0] max_cnt,
    output logic             level,
    output logic             edge_seen,
    output logic             fire
);

    logic [CNT_W-1:0] cnt_q;
    logic             level_q;

    // Detect a PWM level differing from the one being served.
    always_comb begin
        edge_seen = !shutdown && (pwm_in != level_q);
        fire      = rst_n && !shutdown && !edge_seen && (cnt_q == CNT_W'(1));
        level     = level_q;
    end

    // Reload on reset, shutdown or a new level; otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= pwm_in;
            cnt_q   <= max_cnt;
        end else if (shutdown || edge_seen) begin
            level_q <= pwm_in;
            cnt_q   <= load_cnt;
        end else if (cnt_q != '0) begin
            cnt_q   <= cnt_q - CNT_W'(1);
        end
    end

    // R10: the counter never holds more than the longest preset.
    p_cnt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= max_cnt);

    // R5: with the level stable and no shutdown, the count only moves down.
    p_count_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!shutdown && !edge_seen && cnt_q != '0) |=> (cnt_q < $past(cnt_q)));

endmodule

// File: rtl/dt_gate_stage.sv
`timescale 1ns/1ps
// Module: dt_gate_stage
// Holds the two gate-enable registers and applies the combinational
// forced-off gate from shutdown. Both registers drop on a new level and
// turn on only from the fire strobe.
// Assumes level, edge_seen and fire come from dt_interval_timer.
module dt_gate_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic shutdown,
    input  logic level,
    input  logic edge_seen,
    input  logic fire,
    output logic hi_en,
    output logic lo_en
);

    logic hs_q;
    logic ls_q;

    // Drop both on reset, shutdown or new level; enable one side on fire.
    always_ff @(posedge clk) begin
        if (!rst_n || shutdown || edge_seen) begin
            hs_q <= 1'b0;
            ls_q <= 1'b0;
        end else if (fire) begin
            hs_q <= level;
            ls_q <= !level;
        end
    end

    // Forced-off gate: shutdown masks both enables without a clock edge.
    always_comb begin
        hi_en = hs_q && !shutdown;
        lo_en = ls_q && !shutdown;
    end

    // R4: the two enables are never high together.
    p_no_overlap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi_en && lo_en));

    // R1: the high side is only on while serving a high PWM level.
    p_hi_level_r1: assert property (@(posedge clk) disable iff (!rst_n)
        hs_q |-> level);

    // R1: the low side is only on while serving a low PWM level.
    p_lo_level_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ls_q |-> !level);

    // R6: a shutdown cycle leaves both registers cleared.
    p_sd_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |=> (!hs_q && !ls_q));

    // R8: a newly seen level clears both registers at the next edge.
    p_edge_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        edge_seen |=> (!hs_q && !ls_q));

    // R3: a side turns on only after the other side was off.
    p_gap_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_q) |-> $past(!ls_q));

endmodule

// File: rtl/gate_deadtime_gen.sv
`timescale 1ns/1ps
// Module: gate_deadtime_gen
// Turns one PWM input into complementary high/low gate enables, with a
// symmetric non-overlap interval chosen from four presets by dt_mode.
// Shutdown forces both enables off immediately. Assumes a fixed reference
// clock of CLK_PERIOD_PS and a PWM input synchronous to it.
module gate_deadtime_gen
    import dt_gate_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_PS = 1000,
    parameter int unsigned DT_PS_0       = 15000,
    parameter int unsigned DT_PS_1       = 25000,
    parameter int unsigned DT_PS_2       = 35000,
    parameter int unsigned DT_PS_3       = 45000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwm_in,
    input  logic [1:0] dt_mode,
    input  logic       shutdown,
    output logic       hi_en,
    output logic       lo_en
);

    localparam int unsigned MAX_CYC = dt_max4(dt_cycles(DT_PS_0, CLK_PERIOD_PS),
                                              dt_cycles(DT_PS_1, CLK_PERIOD_PS),
                                              dt_cycles(DT_PS_2, CLK_PERIOD_PS),
                                              dt_cycles(DT_PS_3, CLK_PERIOD_PS));
    localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

    logic [CNT_W-1:0] load_cnt;
    logic [CNT_W-1:0] max_cnt;
    logic             level;
    logic             edge_seen;
    logic             fire;

    dt_preset_table #(
        .CLK_PERIOD_PS (CLK_PERIOD_PS),
        .DT_PS_0       (DT_PS_0),
        .DT_PS_1       (DT_PS_1),
        .DT_PS_2       (DT_PS_2),
        .DT_PS_3       (DT_PS_3),
        .CNT_W         (CNT_W)
    ) u_table (
        .mode_code (dt_mode),
        .load_cnt  (load_cnt),
        .max_cnt   (max_cnt)
    );

    dt_interval_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .shutdown  (shutdown),
        .pwm_in    (pwm_in),
        .load_cnt  (load_cnt),
        .max_cnt   (max_cnt),
        .level     (level),
        .edge_seen (edge_seen),
        .fire      (fire)
    );

    dt_gate_stage u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .shutdown  (shutdown),
        .level     (level),
        .edge_seen (edge_seen),
        .fire      (fire),
        .hi_en     (hi_en),
        .lo_en     (lo_en)
    );

endmodule

// File: tb/tb_gate_deadtime_gen.sv
`timescale 1ns/1ps
// Bench: table of PWM edges with expected intervals, then directed tests.
module tb_gate_deadtime_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwm_in = 1'b0;
    logic [1:0] dt_mode = 2'b11;
    logic       shutdown = 1'b0;
    logic       hi_en, lo_en, hi2, lo2;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit done    = 0;

    always #2 clk = ~clk;

    gate_deadtime_gen dut (
        .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .dt_mode(dt_mode),
        .shutdown(shutdown), .hi_en(hi_en), .lo_en(lo_en));

    gate_deadtime_gen #(.CLK_PERIOD_PS(4000)) dut2 (
        .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .dt_mode(dt_mode),
        .shutdown(shutdown), .hi_en(hi2), .lo_en(lo2));

    // Vector: {pwm level, mode code, interval N} from R2.
    localparam logic [10:0] VEC [8] = '{
        {1'b1, 2'b11, 8'd15}, {1'b0, 2'b10, 8'd25},
        {1'b1, 2'b01, 8'd35}, {1'b0, 2'b00, 8'd45},
        {1'b1, 2'b00, 8'd45}, {1'b0, 2'b01, 8'd35},
        {1'b1, 2'b10, 8'd25}, {1'b0, 2'b11, 8'd15}};

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic pick(input int sel);
        case (sel)
            0: return hi_en;
            1: return lo_en;
            2: return hi2;
            default: return lo2;
        endcase
    endfunction

    // Count negedges until output sel rises; the opposite output must stay low.
    task automatic wait_on(input int sel, input int exp, input string req);
        int  got = -1;
        bit  other_hi = 0;
        for (int i = 1; i <= 300; i++) begin
            @(negedge clk);
            if (pick(sel ^ 1)) other_hi = 1;
            if (pick(sel)) begin got = i; break; end
        end
        check(got == exp, req, got, exp);
        check(!other_hi, "R4 opposite output stayed low", int'(other_hi), 0);
    endtask

    task automatic hold_check(input int cycles, input logic lvl, input string req);
        bit bad = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (hi_en !== lvl || lo_en !== !lvl) bad = 1;
        end
        check(!bad, req, int'(bad), 0);
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R9: reset state, then first turn-on uses the longest preset.
        repeat (5) @(negedge clk);
        check(!hi_en && !lo_en, "R9 both low in reset", int'({hi_en, lo_en}), 0);
        rst_n = 1'b1;
        wait_on(1, 45, "R9 first turn-on after reset");

        // R1 R2 R3: table of edges across all mode codes.
        for (int v = 0; v < 8; v++) begin
            @(negedge clk);
            pwm_in  = VEC[v][10];
            dt_mode = VEC[v][9:8];
            wait_on(VEC[v][10] ? 0 : 1, int'(VEC[v][7:0]) + 1, "R2/R3 edge interval");
            hold_check(6, VEC[v][10], "R1 steady levels follow PWM");
        end

        // R5: mode change mid-interval keeps the latched count.
        @(negedge clk);
        pwm_in = 1'b1; dt_mode = 2'b11;
        repeat (3) @(negedge clk);
        dt_mode = 2'b00;
        wait_on(0, 13, "R5 mode change does not alter pending interval");
        @(negedge clk);
        pwm_in = 1'b0;
        wait_on(1, 46, "R5 new mode applies at next edge");

        // R8: level reverts before the interval ends; restart for old level.
        @(negedge clk);
        dt_mode = 2'b01; pwm_in = 1'b1;
        repeat (10) @(negedge clk);
        check(!hi_en && !lo_en, "R8 both off during pending interval",
              int'({hi_en, lo_en}), 0);
        pwm_in = 1'b0;
        wait_on(1, 36, "R8 full interval after revert");

        // R6: shutdown gates the outputs in the same cycle.
        @(negedge clk);
        dt_mode = 2'b11; pwm_in = 1'b1;
        wait_on(0, 16, "R6 setup high side on");
        @(negedge clk);
        shutdown = 1'b1;
        #0.5;
        check(!hi_en && !lo_en, "R6 combinational forced off", int'({hi_en, lo_en}), 0);
        begin
            bit pulse = 0;
            for (int i = 0; i < 60; i++) begin
                @(negedge clk);
                if (i % 7 == 0) pwm_in = ~pwm_in;
                if (hi_en || lo_en) pulse = 1;
            end
            check(!pulse, "R6 no output during shutdown", int'(pulse), 0);
        end

        // R7: release waits a full interval at the current level.
        @(negedge clk);
        pwm_in = 1'b1; dt_mode = 2'b10;
        @(negedge clk);
        shutdown = 1'b0;
        wait_on(0, 25, "R7 turn-on after shutdown release");

        // R10: rounded-up counts at a 4000 ps period.
        @(negedge clk);
        dt_mode = 2'b11; pwm_in = 1'b0;
        wait_on(3, 5, "R10 4000ps period 15ns -> 4 cycles");
        repeat (50) @(negedge clk);
        dt_mode = 2'b00; pwm_in = 1'b1;
        wait_on(2, 13, "R10 4000ps period 45ns -> 12 cycles");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule